// File: doc/BRIEF.md
# Multi-Format Synchronous Serial Master Engine

This block is the bit engine of a serial port that runs as bus master. It takes one parallel word at a time from a transmit source over a valid/ready handshake. It shifts the word out on a serial data pin and drives the serial clock and a frame or select pin. At the same time it collects the bits on the serial input into a word, which it presents with a one-cycle strobe. Three framing styles are available. The first is a select-driven full-duplex style with programmable clock idle level and sampling edge. The second is a pulse-framed full-duplex style whose data driver is switched off between frames. The third is a half-duplex style that sends an 8-bit command and then reads back a response.

The configuration inputs are sampled when a frame starts and are held for the rest of that frame. The serial half period is a whole number of core clock cycles, taken from a divisor. A loopback setting feeds the engine's own data output back into its receiver. The word buffers, the bus register file and slave operation belong to surrounding logic.

Top module: `sx_serial_engine`

## Requirements
- R1: A frame starts at a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` goes low at that edge and returns high one clock after the frame ends. Following reset, `tx_ready` rises on the first edge with `rst` low.
- R2: A frame carries N = `cfg_len_m1`+1 data bits. A `cfg_len_m1` value below 3 gives N = 4.
- R3: Every serial half period lasts H core cycles. H = 1 when `cfg_div` < 2, otherwise H = (`cfg_div`+1)/2, so an odd divisor is rounded up to the next even value. `ser_clk` changes only at half-period boundaries.
- R4: Format codes 0 and 3 (select style): `ser_sel` is low for 2N half periods and `ser_clk` idles at `cfg_cpol`. Bits `tx_data[N-1:0]` go out MSB first, one bit every two half periods. With `cfg_cpha`=0, data is set up before the first clock edge of each bit and sampled on that edge. With `cfg_cpha`=1, data changes on the first edge of each bit and is sampled on the second edge.
- R5: Format code 1 (pulse style): `ser_clk` idles low, each bit period is high then low, and `ser_sel` idles low. `ser_sel` is high for one bit period just before the MSB. `tx_data[N-1:0]` is then sent MSB first and sampled on falling edges.
- R6: Format code 2 (command/response style): `ser_sel` is low and `ser_clk` idles low. First the 8 bits of `tx_data[7:0]` go out MSB first, with data valid while the clock is low. Then N response bits are sampled on the rising edges, with `ser_dout_en` and `ser_dout` held low.
- R7: `ser_dout_en` is high only while the engine is driving a bit: the whole frame in codes 0/3, the N data bits in code 1, and the command bits in code 2. `ser_dout` is 0 whenever `ser_dout_en` is 0.
- R8: `rx_valid` is a one-cycle pulse, raised in the cycle that presents the last sampling edge. At the same time `rx_data` holds the N sampled bits, first sampled in bit N-1, with the upper bits zero. `rx_data` holds its value until the next pulse.
- R9: With `cfg_loop` high, the receiver samples `ser_dout` in place of `ser_din`, and `ser_din` has no effect.
- R10: Changes to configuration inputs during a frame do not alter that frame.
- R11: While `rst` is high: `tx_ready`=0, `rx_valid`=0, `rx_data`=0, `ser_clk`=0, `ser_sel`=1, `ser_dout`=0, `ser_dout_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fmt | input | 2 | Framing style: 0/3 select, 1 pulse, 2 command/response |
| cfg_len_m1 | input | 4 | Data bits per frame minus one |
| cfg_cpol | input | 1 | Clock idle level, select style |
| cfg_cpha | input | 1 | Sampling edge choice, select style |
| cfg_div | input | 8 | Serial clock divisor |
| cfg_loop | input | 1 | Internal loopback |
| tx_data | input | 16 | Word to send |
| tx_valid | input | 1 | Word offered |
| tx_ready | output | 1 | Engine idle and accepting |
| rx_data | output | 16 | Received word, right-aligned |
| rx_valid | output | 1 | Received word strobe |
| ser_clk | output | 1 | Serial clock |
| ser_sel | output | 1 | Select (low active) or frame pulse (high) |
| ser_dout | output | 1 | Serial data out |
| ser_dout_en | output | 1 | Output enable for serial data out |
| ser_din | input | 1 | Serial data in |

## Verification
A wrong slot count or sub-cycle count shows up on `ser_clk` within one half period, as an edge that is early, late or missing. Bad word alignment or a bad bit index shows up on `ser_dout` in the first bit period of a frame. A wrong sampling edge or loopback choice stays hidden until the frame's last edge. It then appears in `rx_data` as a shifted or swapped word. Because every pin is compared against a behavioural model on every clock, any such fault is caught in the cycle where it first appears on a pin.

// File: rtl/sx_pkg.sv
package sx_pkg;
  localparam int MAXW   = 16;
  localparam int CMDW   = 8;
  localparam int LEN_W  = $clog2(MAXW);
  localparam int NB_W   = $clog2(MAXW + 1);
  localparam int SLOT_W = $clog2(2 * (MAXW + CMDW));

  typedef enum logic [1:0] {
    FMT_SEL   = 2'd0,
    FMT_PULSE = 2'd1,
    FMT_CMD   = 2'd2,
    FMT_SEL2  = 2'd3
  } fmt_e;

  typedef struct packed {
    logic            sclk;
    logic            sel;
    logic            oe;
    logic            drv;
    logic            samp;
    logic            last;
    logic [NB_W-1:0] bidx;
  } slot_t;

  // final slot index of a frame
  function automatic logic slot_is_last(input fmt_e fmt, input logic [NB_W-1:0] nbits,
                                        input logic [SLOT_W-1:0] slot);
    logic [SLOT_W-1:0] n2;
    n2 = SLOT_W'(nbits) << 1;
    case (fmt)
      FMT_PULSE: return slot == (n2 + SLOT_W'(1));
      FMT_CMD:   return slot == (n2 + SLOT_W'(2 * CMDW - 1));
      default:   return slot == (n2 - SLOT_W'(1));
    endcase
  endfunction

  // pin levels and strobes for one half-period slot
  function automatic slot_t slot_decode(input fmt_e fmt, input logic cpol, input logic cpha,
                                        input logic [NB_W-1:0] nbits,
                                        input logic [SLOT_W-1:0] slot, input logic act);
    slot_t d;
    logic [SLOT_W-1:0] hb;
    d  = '0;
    hb = '0;
    if (!act) begin
      d.sclk = (fmt == FMT_PULSE || fmt == FMT_CMD) ? 1'b0 : cpol;
      d.sel  = (fmt != FMT_PULSE);
    end else begin
      d.last = slot_is_last(fmt, nbits, slot);
      case (fmt)
        FMT_PULSE: begin
          hb     = (slot - SLOT_W'(2)) >> 1;
          d.sclk = ~slot[0];
          d.sel  = (slot < SLOT_W'(2));
          if (!d.sel) begin
            d.oe   = 1'b1;
            d.drv  = 1'b1;
            d.samp = slot[0];
            d.bidx = hb[NB_W-1:0];
          end
        end
        FMT_CMD: begin
          hb     = slot >> 1;
          d.sclk = slot[0];
          if (slot < SLOT_W'(2 * CMDW)) begin
            d.oe   = 1'b1;
            d.drv  = 1'b1;
            d.bidx = hb[NB_W-1:0];
          end else begin
            d.samp = slot[0];
          end
        end
        default: begin
          hb     = slot >> 1;
          d.sclk = cpol ^ (cpha ? ~slot[0] : slot[0]);
          d.oe   = 1'b1;
          d.drv  = 1'b1;
          d.samp = slot[0];
          d.bidx = hb[NB_W-1:0];
        end
      endcase
    end
    return d;
  endfunction
endpackage

// File: rtl/sx_tick.sv
module sx_tick #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              last
);
  logic [HALF_W-1:0] cnt;

  assign last = run && (cnt == (half - HALF_W'(1)));

  always_ff @(posedge clk) begin
    if (rst || !run || last) cnt <= '0;
    else                     cnt <= cnt + HALF_W'(1);
  end
endmodule

// File: rtl/sx_sequencer.sv
module sx_sequencer
  import sx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tx_valid,
  input  logic [1:0]              cfg_fmt,
  input  logic [LEN_W-1:0]        cfg_len_m1,
  input  logic                    cfg_cpol,
  input  logic                    cfg_cpha,
  input  logic [DIV_W-1:0]        cfg_div,
  output logic                    start,
  output logic                    adv,
  output logic                    act,
  output logic                    tick_last,
  output logic                    rdy,
  output logic                    sclk_q,
  output logic                    sel_q,
  output logic                    oe_q,
  output logic [NB_W-1:0]         nb_live,
  output slot_t                   d_nxt
);
  fmt_e              fmt_q, fmt_s, fmt_live;
  logic              cpol_q, cpha_q, cpol_s, cpha_s;
  logic [NB_W-1:0]   nb_q, nb_s;
  logic [DIV_W-1:0]  half_q, half_live;
  logic [SLOT_W-1:0] slot, slot_n;
  logic              act_n, fin, keep;

  assign fmt_live  = fmt_e'(cfg_fmt);
  assign nb_live   = (cfg_len_m1 < LEN_W'(3)) ? NB_W'(4) : (NB_W'(cfg_len_m1) + NB_W'(1));
  assign half_live = (cfg_div < DIV_W'(2)) ? DIV_W'(1)
                                           : ((cfg_div >> 1) + DIV_W'(cfg_div[0]));

  sx_tick #(.HALF_W(DIV_W)) u_tick (
    .clk (clk),
    .rst (rst),
    .run (act),
    .half(half_q),
    .last(tick_last)
  );

  always_comb begin
    start  = !act && rdy && tx_valid;
    fin    = act && tick_last && slot_is_last(fmt_q, nb_q, slot);
    adv    = act && tick_last && !fin;
    act_n  = start || (act && !fin);
    slot_n = start ? '0 : (adv ? slot + SLOT_W'(1) : slot);
    keep   = act_n && !start;
    fmt_s  = keep ? fmt_q  : fmt_live;
    cpol_s = keep ? cpol_q : cfg_cpol;
    cpha_s = keep ? cpha_q : cfg_cpha;
    nb_s   = keep ? nb_q   : nb_live;
    d_nxt  = slot_decode(fmt_s, cpol_s, cpha_s, nb_s, slot_n, act_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act    <= 1'b0;
      slot   <= '0;
      rdy    <= 1'b0;
      sclk_q <= 1'b0;
      sel_q  <= 1'b1;
      oe_q   <= 1'b0;
      fmt_q  <= FMT_SEL;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      nb_q   <= NB_W'(4);
      half_q <= DIV_W'(1);
    end else begin
      act    <= act_n;
      slot   <= slot_n;
      rdy    <= !act_n;
      sclk_q <= d_nxt.sclk;
      sel_q  <= d_nxt.sel;
      oe_q   <= d_nxt.oe;
      if (start) begin
        fmt_q  <= fmt_live;
        cpol_q <= cfg_cpol;
        cpha_q <= cfg_cpha;
        nb_q   <= nb_live;
        half_q <= half_live;
      end
    end
  end
endmodule

// File: rtl/sx_datapath.sv
module sx_datapath
  import sx_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            adv,
  input  logic [1:0]      cfg_fmt,
  input  logic            cfg_loop,
  input  logic [NB_W-1:0] nb_live,
  input  logic [MAXW-1:0] tx_data,
  input  logic            nxt_drv,
  input  logic            nxt_samp,
  input  logic            nxt_last,
  input  logic [NB_W-1:0] nxt_bidx,
  input  logic            ser_din,
  output logic            sdo_q,
  output logic [MAXW-1:0] rx_data,
  output logic            rx_valid
);
  logic [MAXW-1:0] txw, aligned, src, shf, rxsh, rx_next;
  logic            loop_q, rx_in;

  always_comb begin
    if (fmt_e'(cfg_fmt) == FMT_CMD)
      aligned = MAXW'(tx_data[CMDW-1:0]) << (MAXW - CMDW);
    else
      aligned = tx_data << (NB_W'(MAXW) - nb_live);
    src     = start ? aligned : txw;
    shf     = src << nxt_bidx;
    rx_in   = loop_q ? sdo_q : ser_din;
    rx_next = {rxsh[MAXW-2:0], rx_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txw      <= '0;
      loop_q   <= 1'b0;
      sdo_q    <= 1'b0;
      rxsh     <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      sdo_q    <= nxt_drv ? shf[MAXW-1] : 1'b0;
      if (start) begin
        txw    <= aligned;
        loop_q <= cfg_loop;
        rxsh   <= '0;
      end else if (adv && nxt_samp) begin
        rxsh <= rx_next;
        if (nxt_last) begin
          rx_data  <= rx_next;
          rx_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sx_serial_engine.sv
module sx_serial_engine
  import sx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_fmt,
  input  logic [LEN_W-1:0] cfg_len_m1,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_loop,
  input  logic [MAXW-1:0]  tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [MAXW-1:0]  rx_data,
  output logic             rx_valid,
  output logic             ser_clk,
  output logic             ser_sel,
  output logic             ser_dout,
  output logic             ser_dout_en,
  input  logic             ser_din
);
  logic            start, adv, act, tick_last;
  logic [NB_W-1:0] nb_live;
  slot_t           d_nxt;

  sx_sequencer #(.DIV_W(DIV_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tx_valid  (tx_valid),
    .cfg_fmt   (cfg_fmt),
    .cfg_len_m1(cfg_len_m1),
    .cfg_cpol  (cfg_cpol),
    .cfg_cpha  (cfg_cpha),
    .cfg_div   (cfg_div),
    .start     (start),
    .adv       (adv),
    .act       (act),
    .tick_last (tick_last),
    .rdy       (tx_ready),
    .sclk_q    (ser_clk),
    .sel_q     (ser_sel),
    .oe_q      (ser_dout_en),
    .nb_live   (nb_live),
    .d_nxt     (d_nxt)
  );

  sx_datapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .adv     (adv),
    .cfg_fmt (cfg_fmt),
    .cfg_loop(cfg_loop),
    .nb_live (nb_live),
    .tx_data (tx_data),
    .nxt_drv (d_nxt.drv),
    .nxt_samp(d_nxt.samp),
    .nxt_last(d_nxt.last),
    .nxt_bidx(d_nxt.bidx),
    .ser_din (ser_din),
    .sdo_q   (ser_dout),
    .rx_data (rx_data),
    .rx_valid(rx_valid)
  );
endmodule

// File: rtl/sx_serial_engine_chk.sv
module sx_serial_engine_chk (
  input logic clk,
  input logic rst,
  input logic tx_valid,
  input logic tx_ready,
  input logic rx_valid,
  input logic ser_clk,
  input logic ser_dout,
  input logic ser_dout_en,
  input logic act,
  input logic tick_last
);
  AST_RDY_DROP: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_ready); // R1
  AST_START_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
    $rose(act) |-> $past(tx_valid && tx_ready)); // R1
  AST_HALF_STEADY: assert property (@(posedge clk) disable iff (rst)
    (act && !tick_last) |=> $stable(ser_clk)); // R3
  AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ser_dout_en |-> !ser_dout); // R7
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !act |-> !ser_dout_en); // R7
  AST_RXV_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R8
  AST_RXV_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> act); // R8
endmodule

bind sx_serial_engine sx_serial_engine_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .rx_valid   (rx_valid),
  .ser_clk    (ser_clk),
  .ser_dout   (ser_dout),
  .ser_dout_en(ser_dout_en),
  .act        (act),
  .tick_last  (tick_last)
);

// File: tb/sim_sx_serial_engine.sv
module sim_sx_serial_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_fmt = '0;
  logic [3:0]  cfg_len_m1 = 4'd7;
  logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_loop = 1'b0;
  logic [7:0]  cfg_div = 8'd2;
  logic [15:0] tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        ser_din = 1'b0;
  logic        tx_ready, rx_valid, ser_clk, ser_sel, ser_dout, ser_dout_en;
  logic [15:0] rx_data;

  always #10 clk = ~clk;

  sx_serial_engine u0 (
    .clk(clk), .rst(rst), .cfg_fmt(cfg_fmt), .cfg_len_m1(cfg_len_m1),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_div(cfg_div), .cfg_loop(cfg_loop),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .ser_clk(ser_clk), .ser_sel(ser_sel),
    .ser_dout(ser_dout), .ser_dout_en(ser_dout_en), .ser_din(ser_din)
  );

  int total = 0, bad = 0;
  bit done = 0, cmp_on = 0;

  // behavioural reference state
  bit m_act = 0, m_cpol = 0, m_cpha = 0, m_loop = 0;
  int m_slot = 0, m_cnt = 0, m_half = 1, m_fmt = 0, m_n = 4;
  logic [15:0] m_word = '0, m_rx = '0, e_rxd = '0;
  bit e_rdy = 0, e_rxv = 0, e_sclk = 0, e_sel = 1, e_sdo = 0, e_oe = 0;

  logic [15:0] got_q[$];
  logic [15:0] lfsr = 16'hACE1;
  bit din_fixed = 0, din_val = 0;

  function automatic int half_of(int d); return (d < 2) ? 1 : (d + 1) / 2; endfunction
  function automatic int bits_of(int l); return (l < 3) ? 4 : l + 1; endfunction
  function automatic int slots_of(int f, int n);
    if (f == 1) return 2 * n + 2;
    if (f == 2) return 16 + 2 * n;
    return 2 * n;
  endfunction
  function automatic bit samples(int f, int s);
    if (f == 1) return s >= 2 && (s % 2 == 1);
    if (f == 2) return s >= 16 && (s % 2 == 1);
    return s % 2 == 1;
  endfunction

  task automatic model_pins();
    if (!m_act) begin
      e_sclk = (cfg_fmt == 2'd1 || cfg_fmt == 2'd2) ? 1'b0 : cfg_cpol;
      e_sel  = (cfg_fmt != 2'd1);
      e_oe = 0; e_sdo = 0;
    end else if (m_fmt == 1) begin
      e_sclk = (m_slot % 2 == 0);
      e_sel  = (m_slot < 2);
      e_oe   = (m_slot >= 2);
      e_sdo  = (m_slot >= 2) ? m_word[m_n - 1 - (m_slot - 2) / 2] : 1'b0;
    end else if (m_fmt == 2) begin
      e_sclk = (m_slot % 2 == 1);
      e_sel  = 0;
      e_oe   = (m_slot < 16);
      e_sdo  = (m_slot < 16) ? m_word[7 - m_slot / 2] : 1'b0;
    end else begin
      e_sclk = m_cpol ^ (m_cpha ? (m_slot % 2 == 0) : (m_slot % 2 == 1));
      e_sel  = 0;
      e_oe   = 1;
      e_sdo  = m_word[m_n - 1 - m_slot / 2];
    end
  endtask

  always @(posedge clk) begin
    bit rin;
    if (rst) begin
      m_act = 0; m_slot = 0; m_cnt = 0; e_rdy = 0; e_rxv = 0; e_rxd = '0;
      e_sclk = 0; e_sel = 1; e_sdo = 0; e_oe = 0;
    end else begin
      rin   = m_loop ? e_sdo : ser_din;
      e_rxv = 0;
      if (!m_act) begin
        if (tx_valid && e_rdy) begin
          m_act = 1; m_slot = 0; m_cnt = 0; m_rx = '0;
          m_fmt = int'(cfg_fmt); m_n = bits_of(int'(cfg_len_m1));
          m_cpol = cfg_cpol; m_cpha = cfg_cpha; m_loop = cfg_loop;
          m_half = half_of(int'(cfg_div)); m_word = tx_data;
        end
      end else if (m_cnt == m_half - 1) begin
        m_cnt = 0;
        if (m_slot == slots_of(m_fmt, m_n) - 1) m_act = 0;
        else begin
          m_slot++;
          if (samples(m_fmt, m_slot)) begin
            m_rx = {m_rx[14:0], rin};
            if (m_slot == slots_of(m_fmt, m_n) - 1) begin e_rxv = 1; e_rxd = m_rx; end
          end
        end
      end else m_cnt++;
      e_rdy = !m_act;
      model_pins();
    end
  end

  task automatic check(bit ok, string tag, string what, int act_v, int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act_v, exp_v, $time);
    end
  endtask

  // per-cycle comparison, input drive and word capture on the falling edge
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check(tx_ready == e_rdy, "R1", "tx_ready", tx_ready, e_rdy);
      check(ser_clk == e_sclk, "R3", "ser_clk", ser_clk, e_sclk);
      check(ser_sel == e_sel, "R4", "ser_sel", ser_sel, e_sel);
      check(ser_dout == e_sdo, "R6", "ser_dout", ser_dout, e_sdo);
      check(ser_dout_en == e_oe, "R5", "ser_dout_en", ser_dout_en, e_oe);
      check(ser_dout_en || !ser_dout, "R7", "dout while disabled", ser_dout, 0);
      check(rx_valid == e_rxv, "R8", "rx_valid", rx_valid, e_rxv);
      check(rx_data == e_rxd, "R8", "rx_data", rx_data, e_rxd);
      if (rx_valid) got_q.push_back(rx_data);
    end
    lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ser_din = din_fixed ? din_val : lfsr[0];
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic setcfg(int f, int l, bit cp, bit ph, int d, bit lp);
    cfg_fmt = 2'(f); cfg_len_m1 = 4'(l); cfg_cpol = cp; cfg_cpha = ph;
    cfg_div = 8'(d); cfg_loop = lp;
    @(negedge clk);
  endtask

  task automatic send(logic [15:0] w);
    tx_data = w; tx_valid = 1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic wait_idle();
    while (!tx_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_word(logic [15:0] exp, string tag);
    logic [15:0] g;
    check(got_q.size() > 0, tag, "word count", got_q.size(), 1);
    if (got_q.size() > 0) begin
      g = got_q.pop_front();
      check(g == exp, tag, "received word", g, exp);
    end
  endtask

  task automatic xfer(logic [15:0] w, logic [15:0] exp, string tag);
    send(w); wait_idle(); expect_word(exp, tag);
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp_on = 1;
    // R11: reset values
    check(tx_ready == 0 && rx_valid == 0 && rx_data == 0, "R11", "reset status", tx_ready, 0);
    check(ser_clk == 0 && ser_sel == 1 && ser_dout == 0 && ser_dout_en == 0,
          "R11", "reset pins", {ser_clk, ser_sel, ser_dout, ser_dout_en}, 4'b0100);
    rst = 0;
    @(negedge clk);
    check(tx_ready == 1, "R1", "ready after reset", tx_ready, 1);

    // R4 + R9: select style, mode 0, loopback with noise on ser_din
    setcfg(0, 7, 0, 0, 4, 1);
    xfer(16'hA5C3, 16'h00C3, "R9");
    // R4 + R3: inverted clock, second-edge sampling, odd divisor
    setcfg(0, 15, 1, 1, 3, 1);
    xfer(16'h9B2E, 16'h9B2E, "R4");
    // R2: short length clamps to 4 bits, divisor 0
    setcfg(0, 1, 0, 1, 0, 1);
    xfer(16'h00F6, 16'h0006, "R2");
    // R5: pulse style loopback
    setcfg(1, 11, 1, 0, 2, 1);
    xfer(16'h0ABC, 16'h0ABC, "R5");
    // R6: command style loopback reads back zeros
    setcfg(2, 7, 0, 0, 6, 1);
    xfer(16'h12C5, 16'h0000, "R6");
    // R6: command style, response all ones from ser_din
    din_fixed = 1; din_val = 1;
    setcfg(2, 4, 1, 1, 2, 0);
    xfer(16'h003A, 16'h001F, "R6");
    din_fixed = 0;
    // R4: format code 3 behaves as select style
    setcfg(3, 9, 0, 0, 2, 1);
    xfer(16'hF2D7, 16'h02D7, "R4");
    // R10: configuration changed mid-frame
    setcfg(0, 7, 0, 0, 8, 1);
    send(16'h0081);
    repeat (5) @(negedge clk);
    cfg_len_m1 = 4'd15; cfg_div = 8'd2; cfg_fmt = 2'd1; cfg_cpol = 1; cfg_loop = 0;
    wait_idle();
    expect_word(16'h0081, "R10");
    // R1: back-to-back words, random ser_din
    setcfg(0, 5, 0, 1, 5, 0);
    send(16'h0015);
    send(16'h002A);
    wait_idle();
    check(got_q.size() == 2, "R1", "back-to-back word count", got_q.size(), 2);
    got_q.delete();
    // R5: pulse style with random ser_din
    setcfg(1, 3, 0, 0, 4, 0);
    send(16'h0009);
    wait_idle();
    check(got_q.size() == 1, "R5", "pulse frame word count", got_q.size(), 1);
    got_q.delete();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule